// File: doc/BRIEF.md
# Per-Core Interrupt Request Routing Switch

Each processor core has two active-low request lines into it, a normal request and a fast request. This block decides what drives those lines, one lane per core. In legacy mode, a core's own pair of dedicated active-low request pins is wired straight through to that core. This path has no flop and no clock, so the core output follows the pin at once. In routed mode, the interrupt controller's prioritised requests drive the core through one register in the controller clock domain. The dedicated pins then become ordinary private interrupt sources. They pass through a two-flop synchroniser and are reported as pending to the distributor, the fast pin as ID 28 and the normal pin as ID 31.

The mode of each lane comes from the enable bit that the per-core interface control register supplies on `if_en`. Each lane holds its mode in a two-state machine: `LANE_LEGACY` and `LANE_ROUTED`. The transition `EN_RISE` (LEGACY to ROUTED) is taken on a controller clock edge that samples `if_en` high. The transition `EN_FALL` (ROUTED to LEGACY) is taken on an edge that samples it low. The output multiplexer is steered only by this registered state, so a change of the enable bit cannot glitch the core lines between edges.

A core's pins never reach another core's outputs or pending bits. Reset puts every lane in `LANE_LEGACY`.

Top module: `core_irq_route`

## Requirements
- R1: While reset is asserted and after it, every lane is in legacy mode: core outputs equal the core's own pins and both pending outputs are 0.
- R2: In legacy mode, `core_irq_n[i]` equals `legacy_irq_n[i]` and `core_fiq_n[i]` equals `legacy_fiq_n[i]` combinationally, with no clock edge needed.
- R3: In legacy mode, the controller requests `ctl_irq_req`/`ctl_fiq_req` have no effect on the core outputs, and the pending outputs stay 0 even when a pin is low.
- R4: A change of `if_en[i]` switches lane i's mode only at the next controller clock edge, never before it.
- R5: In routed mode, `core_irq_n[i]` is the inverse of `ctl_irq_req[i]` (and likewise for the fast line) as sampled at the previous clock edge. The lines idle high when no request is present.
- R6: In routed mode, the legacy pins have no effect on the core outputs.
- R7: In routed mode, a low `legacy_fiq_n[i]` sets `ppi_fiq_pend[i]` after exactly two clock edges, and `ppi_fiq_id` reports 28.
- R8: In routed mode, a low `legacy_irq_n[i]` sets `ppi_irq_pend[i]` after exactly two clock edges, and `ppi_irq_id` reports 31.
- R9: The pins of a core affect only that core's outputs and pending bits.
- R10: On the edge that returns a lane to legacy mode, its pending bits fall to 0 and its outputs follow the pins again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | NUM_CORES | Per-core interface enable bit (1 = routed mode) |
| legacy_irq_n | input | NUM_CORES | Dedicated active-low normal request pin per core |
| legacy_fiq_n | input | NUM_CORES | Dedicated active-low fast request pin per core |
| ctl_irq_req | input | NUM_CORES | Controller normal request per core, active high |
| ctl_fiq_req | input | NUM_CORES | Controller fast request per core, active high |
| core_irq_n | output | NUM_CORES | Active-low normal request to each core |
| core_fiq_n | output | NUM_CORES | Active-low fast request to each core |
| ppi_irq_pend | output | NUM_CORES | Synchronised normal pin pending, routed mode only |
| ppi_fiq_pend | output | NUM_CORES | Synchronised fast pin pending, routed mode only |
| ppi_irq_id | output | ID_W | Private interrupt ID of the normal pin (31) |
| ppi_fiq_id | output | ID_W | Private interrupt ID of the fast pin (28) |

## Verification
A pin that changes between clock edges tells the unclocked legacy path apart from any registered path, because the output is checked before the next edge arrives. Controller requests raised while a lane is legacy, and pins pulled low while it is routed, show that each mode ignores the other mode's source. A low pin in routed mode, sampled one edge and then two edges later, pins down the synchroniser depth. Toggling the enable bit, with the output checked both before and after the edge, separates a registered select from a combinational one. Every stimulus is applied to one core while the other cores are watched, which exposes any crossing between lanes.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

    typedef enum logic {
        LANE_LEGACY = 1'b0,
        LANE_ROUTED = 1'b1
    } lane_state_e;

    typedef struct packed {
        logic irq;
        logic fiq;
    } req_pair_t;

endpackage

// File: rtl/irq_pin_sync.sv
`timescale 1ns/1ps
module irq_pin_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_route_lane.sv
`timescale 1ns/1ps
module irq_route_lane
    import irq_route_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic if_en,
    input  logic leg_irq_n,
    input  logic leg_fiq_n,
    input  logic ctl_irq,
    input  logic ctl_fiq,
    output logic core_irq_n,
    output logic core_fiq_n,
    output logic pend_irq,
    output logic pend_fiq,
    output logic routed
);
    lane_state_e state_q, state_d;
    req_pair_t   ctl_q;
    req_pair_t   pin_sync;
    req_pair_t   pin_act;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_LEGACY;
        else        state_q <= state_d;
    end

    // transitions: EN_RISE and EN_FALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_LEGACY: if (if_en)  state_d = LANE_ROUTED;
            LANE_ROUTED: if (!if_en) state_d = LANE_LEGACY;
        endcase
    end

    // controller-side request register (controller clock latency)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= '{irq: ctl_irq, fiq: ctl_fiq};
    end

    // the dedicated pins as active-high sources into the synchroniser
    assign pin_act = '{irq: ~leg_irq_n, fiq: ~leg_fiq_n};

    irq_pin_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_act),
        .q     (pin_sync)
    );

    // outputs, steered only by the registered state
    always_comb begin
        unique case (state_q)
            LANE_LEGACY: begin
                core_irq_n = leg_irq_n;
                core_fiq_n = leg_fiq_n;
                pend_irq   = 1'b0;
                pend_fiq   = 1'b0;
            end
            LANE_ROUTED: begin
                core_irq_n = ~ctl_q.irq;
                core_fiq_n = ~ctl_q.fiq;
                pend_irq   = pin_sync.irq;
                pend_fiq   = pin_sync.fiq;
            end
        endcase
    end

    assign routed = (state_q == LANE_ROUTED);
endmodule

// File: rtl/core_irq_route.sv
`timescale 1ns/1ps
module core_irq_route #(
    parameter int NUM_CORES   = 4,
    parameter int ID_W        = 5,
    parameter int FIQ_PPI_ID  = 28,
    parameter int IRQ_PPI_ID  = 31,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] if_en,
    input  logic [NUM_CORES-1:0] legacy_irq_n,
    input  logic [NUM_CORES-1:0] legacy_fiq_n,
    input  logic [NUM_CORES-1:0] ctl_irq_req,
    input  logic [NUM_CORES-1:0] ctl_fiq_req,
    output logic [NUM_CORES-1:0] core_irq_n,
    output logic [NUM_CORES-1:0] core_fiq_n,
    output logic [NUM_CORES-1:0] ppi_irq_pend,
    output logic [NUM_CORES-1:0] ppi_fiq_pend,
    output logic [ID_W-1:0]      ppi_irq_id,
    output logic [ID_W-1:0]      ppi_fiq_id
);
    localparam logic [ID_W-1:0] FIQ_ID_V = ID_W'(FIQ_PPI_ID);
    localparam logic [ID_W-1:0] IRQ_ID_V = ID_W'(IRQ_PPI_ID);

    logic [NUM_CORES-1:0] lane_routed;

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_lane
        irq_route_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .if_en      (if_en[i]),
            .leg_irq_n  (legacy_irq_n[i]),
            .leg_fiq_n  (legacy_fiq_n[i]),
            .ctl_irq    (ctl_irq_req[i]),
            .ctl_fiq    (ctl_fiq_req[i]),
            .core_irq_n (core_irq_n[i]),
            .core_fiq_n (core_fiq_n[i]),
            .pend_irq   (ppi_irq_pend[i]),
            .pend_fiq   (ppi_fiq_pend[i]),
            .routed     (lane_routed[i])
        );
    end

    assign ppi_irq_id = IRQ_ID_V;
    assign ppi_fiq_id = FIQ_ID_V;
endmodule

// File: rtl/core_irq_route_chk.sv
`timescale 1ns/1ps
module core_irq_route_chk #(
    parameter int NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] if_en,
    input logic [NUM_CORES-1:0] legacy_irq_n,
    input logic [NUM_CORES-1:0] legacy_fiq_n,
    input logic [NUM_CORES-1:0] ctl_irq_req,
    input logic [NUM_CORES-1:0] core_irq_n,
    input logic [NUM_CORES-1:0] core_fiq_n,
    input logic [NUM_CORES-1:0] ppi_irq_pend,
    input logic [NUM_CORES-1:0] ppi_fiq_pend,
    input logic [NUM_CORES-1:0] lane_routed
);
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
        // R2
        legacy_irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_routed[i] |-> core_irq_n[i] == legacy_irq_n[i]);
        // R2
        legacy_fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_routed[i] |-> core_fiq_n[i] == legacy_fiq_n[i]);
        // R4
        mode_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> lane_routed[i] == $past(if_en[i]));
        // R5
        routed_irq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && lane_routed[i]) |-> core_irq_n[i] == !$past(ctl_irq_req[i]));
        // R3
        legacy_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_routed[i] |-> (!ppi_irq_pend[i] && !ppi_fiq_pend[i]));
        // R7
        fiq_pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ppi_fiq_pend[i]) && $past(lane_routed[i])) |-> !$past(legacy_fiq_n[i], 2));
        // R8
        irq_pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ppi_irq_pend[i]) && $past(lane_routed[i])) |-> !$past(legacy_irq_n[i], 2));
    end
endmodule

bind core_irq_route core_irq_route_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .if_en        (if_en),
    .legacy_irq_n (legacy_irq_n),
    .legacy_fiq_n (legacy_fiq_n),
    .ctl_irq_req  (ctl_irq_req),
    .core_irq_n   (core_irq_n),
    .core_fiq_n   (core_fiq_n),
    .ppi_irq_pend (ppi_irq_pend),
    .ppi_fiq_pend (ppi_fiq_pend),
    .lane_routed  (lane_routed)
);

// File: tb/core_irq_route_tb_top.sv
`timescale 1ns/100ps
module core_irq_route_tb_top;
    localparam int NC = 4;

    typedef struct {
        string req;
        int    core;
        int    sel;   // 0 core_irq_n, 1 core_fiq_n, 2 ppi_irq_pend, 3 ppi_fiq_pend
        logic  exp;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] if_en = '0;
    logic [NC-1:0] legacy_irq_n = '1;
    logic [NC-1:0] legacy_fiq_n = '1;
    logic [NC-1:0] ctl_irq_req = '0;
    logic [NC-1:0] ctl_fiq_req = '0;
    logic [NC-1:0] core_irq_n, core_fiq_n, ppi_irq_pend, ppi_fiq_pend;
    logic [4:0]    ppi_irq_id, ppi_fiq_id;

    int        checks = 0;
    int        errors = 0;
    bit        done = 1'b0;
    exp_item_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    core_irq_route #(.NUM_CORES(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .if_en(if_en),
        .legacy_irq_n(legacy_irq_n), .legacy_fiq_n(legacy_fiq_n),
        .ctl_irq_req(ctl_irq_req), .ctl_fiq_req(ctl_fiq_req),
        .core_irq_n(core_irq_n), .core_fiq_n(core_fiq_n),
        .ppi_irq_pend(ppi_irq_pend), .ppi_fiq_pend(ppi_fiq_pend),
        .ppi_irq_id(ppi_irq_id), .ppi_fiq_id(ppi_fiq_id)
    );

    function automatic logic pick(int core, int sel);
        case (sel)
            0:       return core_irq_n[core];
            1:       return core_fiq_n[core];
            2:       return ppi_irq_pend[core];
            default: return ppi_fiq_pend[core];
        endcase
    endfunction

    task automatic check(string req, int core, int sel, logic exp);
        logic act;
        act = pick(core, sel);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s core%0d sel%0d: actual=%b expected=%b", req, core, sel, act, exp);
        end
    endtask

    task automatic check_id(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s id: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver side: expectation for the next sampling point (after the coming edge)
    task automatic expect_next(string req, int core, int sel, logic exp);
        exp_item_t it;
        it.req = req; it.core = core; it.sel = sel; it.exp = exp;
        exp_q.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares queued expectations 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.req, it.core, it.sel, it.exp);
            end
        end
    end

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        // R1: during reset, legacy bypass
        legacy_fiq_n[0] = 1'b0;
        ctl_irq_req[1] = 1'b1;
        #7;
        check("R1", 0, 1, 1'b0);
        check("R1", 1, 0, 1'b1);
        check("R1", 0, 3, 1'b0);
        step(2);
        rst_n = 1'b1;
        ctl_irq_req[1] = 1'b0;
        legacy_fiq_n[0] = 1'b1;
        step(1);
        expect_next("R1", 0, 1, 1'b1);
        expect_next("R1", 2, 2, 1'b0);
        step(1);

        // R2/R9: unclocked bypass, checked before any edge
        @(posedge clk); #1;
        legacy_irq_n[1] = 1'b0;
        #0.5;
        check("R2", 1, 0, 1'b0);
        check("R9", 0, 0, 1'b1);
        check("R9", 2, 0, 1'b1);
        legacy_irq_n[1] = 1'b1;
        #0.5;
        check("R2", 1, 0, 1'b1);

        // R3: controller requests and pins ignored for pending in legacy
        step(1);
        ctl_irq_req[2] = 1'b1;
        ctl_fiq_req[2] = 1'b1;
        legacy_fiq_n[2] = 1'b0;
        expect_next("R3", 2, 0, 1'b1);
        step(1);
        step(1);
        expect_next("R3", 2, 1, 1'b0);
        expect_next("R3", 2, 3, 1'b0);
        step(1);
        legacy_fiq_n[2] = 1'b1;
        step(3);

        // R4: enable takes effect only at the edge
        if_en[2] = 1'b1;
        #0.5;
        check("R4", 2, 0, 1'b1);
        expect_next("R4", 2, 0, 1'b0);
        expect_next("R4", 2, 1, 1'b0);
        step(1);

        // R5: idle high, then one-edge latency
        ctl_irq_req[2] = 1'b0;
        ctl_fiq_req[2] = 1'b0;
        expect_next("R5", 2, 0, 1'b1);
        expect_next("R5", 2, 1, 1'b1);
        step(1);
        ctl_fiq_req[2] = 1'b1;
        #0.5;
        check("R5", 2, 1, 1'b1);
        expect_next("R5", 2, 1, 1'b0);
        step(1);
        ctl_fiq_req[2] = 1'b0;
        step(1);

        // R7/R6: fast pin as private interrupt on core 3
        if_en[3] = 1'b1;
        step(2);
        legacy_fiq_n[3] = 1'b0;
        #0.5;
        check("R6", 3, 1, 1'b1);
        expect_next("R7", 3, 3, 1'b0);
        step(1);
        expect_next("R7", 3, 3, 1'b1);
        expect_next("R6", 3, 1, 1'b1);
        expect_next("R9", 2, 3, 1'b0);
        step(1);
        check_id("R7", ppi_fiq_id, 5'd28);

        // R8: normal pin as private interrupt on core 3
        legacy_irq_n[3] = 1'b0;
        expect_next("R8", 3, 2, 1'b0);
        step(1);
        expect_next("R8", 3, 2, 1'b1);
        expect_next("R6", 3, 0, 1'b1);
        step(1);
        check_id("R8", ppi_irq_id, 5'd31);

        // R10: back to legacy clears pending, pins drive cores again
        if_en[3] = 1'b0;
        #0.5;
        check("R4", 3, 3, 1'b1);
        expect_next("R10", 3, 3, 1'b0);
        expect_next("R10", 3, 2, 1'b0);
        expect_next("R10", 3, 1, 1'b0);
        expect_next("R10", 3, 0, 1'b0);
        step(1);
        legacy_irq_n[3] = 1'b1;
        legacy_fiq_n[3] = 1'b1;
        expect_next("R10", 3, 0, 1'b1);
        step(2);

        done = 1'b1;
        summary();
    end
endmodule